// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Selection

This block keeps a 16-bit count driven by an external input pin. In event mode it adds one for each selected edge of the pin. In gated mode it adds one for each tick of a bus-clock/64 strobe, but only while the pin sits at its active level. This second mode measures how long the pin stays active. The bus-clock/64 strobe comes from the main timer's prescaler, so gated accumulation stops while the main timer is switched off. Event counting does not depend on the main timer.

The block sets two sticky flags, each with its own interrupt enable. The input flag is set by the pin edge that is counted in event mode, or by the edge that ends the active phase in gated mode. The overflow flag is set when the count wraps from its maximum back to zero. Software clears a flag by writing 1 to it.

The accumulator increment can also drive the main timer counter. A two-bit field picks one of four sources for the timer counter's tick strobe:
- the timer prescaler tick;
- every accumulator increment;
- every 256th increment;
- every 65536th increment.

The divided sources are one-cycle strobes taken from carries in the count.

Top module: `pulse_acc`

## Requirements
- R1: After reset, acc_count is 0, both flags and both interrupt requests are 0, the control register is 0, and tcnt_tick follows presc_tick.
- R2: Control bit 0 enables the block. It works on its own: event counting runs with tmr_en at 0. While the block is disabled, the count does not change except by a load, and no flag is set.
- R3: With control bit 1 at 0 (event mode), the count adds one per selected edge of the synchronised pin. Control bit 2 picks the edge: 0 selects falling edges, 1 selects rising edges. Each counted edge also sets the input flag. An edge driven between clock edges shows in acc_count after the third rising clock edge.
- R4: With control bit 1 at 1 (gated mode), the count adds one on each div64_tick while tmr_en is 1 and the synchronised pin is at its active level. The active level is high when control bit 2 is 0 and low when it is 1. With tmr_en at 0, the count holds.
- R5: In gated mode, the edge that ends the active phase sets the input flag. This is the falling edge when control bit 2 is 0 and the rising edge when it is 1.
- R6: An increment from 0xFFFF gives 0x0000 and sets the overflow flag.
- R7: A flag-clear write with flag_clr bit 0 set clears the input flag. Bit 1 clears the overflow flag. A set that happens in the same cycle wins over the clear.
- R8: irq_in is the input flag ANDed with control bit 3. irq_ovf is the overflow flag ANDed with control bit 4.
- R9: Control bits 6:5 select the timer counter tick while the block is enabled:
  - 00 gives presc_tick;
  - 01 gives each increment;
  - 10 gives the increment that carries out of the low 8 bits;
  - 11 gives the increment that wraps the count.
  A new value acts from the cycle after the write.
- R10: While control bit 0 is 0, tcnt_tick equals presc_tick whatever bits 6:5 hold.
- R11: cnt_we loads cnt_wdata into the count on the next clock edge. A load wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Main timer enable |
| presc_tick | input | 1 | Timer prescaler tick strobe |
| div64_tick | input | 1 | Bus-clock/64 strobe from the prescaler |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control write data (bit0 enable, bit1 mode, bit2 edge select, bit3 input IE, bit4 overflow IE, bits 6:5 clock select) |
| cnt_we | input | 1 | Count load strobe |
| cnt_wdata | input | 16 | Count load value |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 2 | Write-1-to-clear mask (bit0 input flag, bit1 overflow flag) |
| acc_count | output | 16 | Accumulator count |
| in_flag | output | 1 | Input edge flag |
| ovf_flag | output | 1 | Overflow flag |
| irq_in | output | 1 | Input interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| tcnt_tick | output | 1 | Selected tick strobe for the main timer counter |

## Verification
The bench checks these corner cases:

- **Edge polarity in both modes.** A design that mixed up the polarity would count the wrong edge in event mode, or set the gated-mode flag at the start of the active phase instead of its end.
- **Gated mode with the timer off.** A design that ignored tmr_en would keep accumulating while no bus-clock/64 strobe should exist.
- **Wrap from 0xFFFF and the divided clock sources.** A carry taken from the wrong bit would fire the divide-by-256 or divide-by-65536 strobe on the wrong increment, or miss the overflow flag.
- **Disabled block with a non-zero clock-select field.** A design that did not force the prescaler source here would starve or over-clock the timer counter.
- **Exact three-edge pin latency.** An extra or missing synchroniser stage shows as a count that changes one cycle late or early.

// File: rtl/pulse_acc.sv
module pulse_acc #(
  parameter int CNT_W  = 16,
  parameter int LO_W   = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic             presc_tick,
  input  logic             div64_tick,
  input  logic             pin_in,
  input  logic             ctl_we,
  input  logic [6:0]       ctl_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             flag_clr_we,
  input  logic [1:0]       flag_clr,
  output logic [CNT_W-1:0] acc_count,
  output logic             in_flag,
  output logic             ovf_flag,
  output logic             irq_in,
  output logic             irq_ovf,
  output logic             tcnt_tick
);

  logic [6:0]      ctl;
  logic [SYNC_N:0] sh;

  logic       en, mode, esel, ie_in, ie_ovf;
  logic [1:0] csel;

  assign en     = ctl[0];
  assign mode   = ctl[1];
  assign esel   = ctl[2];
  assign ie_in  = ctl[3];
  assign ie_ovf = ctl[4];
  assign csel   = ctl[6:5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
      sh  <= '0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata;
      sh <= {sh[SYNC_N-1:0], pin_in};
    end
  end

  logic cur, prev, end_edge, active, inc;
  logic lo_carry, full_carry;

  assign cur        = sh[SYNC_N-1];
  assign prev       = sh[SYNC_N];
  assign end_edge   = esel ? (cur & ~prev) : (~cur & prev);
  assign active     = esel ? ~cur : cur;
  assign inc        = en & (mode ? (tmr_en & div64_tick & active) : end_edge);
  assign lo_carry   = &acc_count[LO_W-1:0];
  assign full_carry = &acc_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_count <= '0;
      in_flag   <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (cnt_we)   acc_count <= cnt_wdata;
      else if (inc) acc_count <= acc_count + 1'b1;
      in_flag  <= (en & end_edge) | (in_flag & ~(flag_clr_we & flag_clr[0]));
      ovf_flag <= (inc & full_carry & ~cnt_we) | (ovf_flag & ~(flag_clr_we & flag_clr[1]));
    end
  end

  assign irq_in  = in_flag & ie_in;
  assign irq_ovf = ovf_flag & ie_ovf;

  always_comb begin
    tcnt_tick = presc_tick;
    if (en) begin
      case (csel)
        2'b01:   tcnt_tick = inc;
        2'b10:   tcnt_tick = inc & lo_carry;
        2'b11:   tcnt_tick = inc & full_carry;
        default: tcnt_tick = presc_tick;
      endcase
    end
  end

endmodule

module pulse_acc_chk #(
  parameter int CNT_W = 16,
  parameter int LO_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mode,
  input logic [1:0]       csel,
  input logic             tmr_en,
  input logic             cnt_we,
  input logic [CNT_W-1:0] acc_count,
  input logic             ovf_flag,
  input logic             tcnt_tick
);

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_we) |=> $stable(acc_count)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (acc_count == $past(acc_count) || acc_count == CNT_W'($past(acc_count) + 1'b1))); // R3

  AST_GATED_NEEDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && !tmr_en && !cnt_we) |=> $stable(acc_count)); // R4

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_count == '0 && $past(&acc_count) && !$past(cnt_we) && $past(acc_count) != acc_count) |-> ovf_flag); // R6

  AST_DIV256_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && csel == 2'b10 && tcnt_tick && !cnt_we) |=> acc_count[LO_W-1:0] == '0); // R9

  AST_DIV64K_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && csel == 2'b11 && tcnt_tick && !cnt_we) |=> (acc_count == '0 && ovf_flag)); // R9

endmodule

bind pulse_acc pulse_acc_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .csel(csel), .tmr_en(tmr_en),
  .cnt_we(cnt_we), .acc_count(acc_count), .ovf_flag(ovf_flag), .tcnt_tick(tcnt_tick)
);

// File: tb/test_pulse_acc.sv
`timescale 1ns/1ps
module test_pulse_acc;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_en = 1'b0, presc_tick = 1'b0, div64_tick = 1'b0, pin_in = 1'b0;
  logic ctl_we = 1'b0, cnt_we = 1'b0, flag_clr_we = 1'b0;
  logic [6:0]  ctl_wdata = '0;
  logic [15:0] cnt_wdata = '0;
  logic [1:0]  flag_clr = '0;
  logic [15:0] acc_count;
  logic in_flag, ovf_flag, irq_in, irq_ovf, tcnt_tick;

  always #5 clk = ~clk;

  pulse_acc i_pulse_acc (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .presc_tick(presc_tick),
    .div64_tick(div64_tick), .pin_in(pin_in), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
    .acc_count(acc_count), .in_flag(in_flag), .ovf_flag(ovf_flag), .irq_in(irq_in),
    .irq_ovf(irq_ovf), .tcnt_tick(tcnt_tick)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int cyc = 0;
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    div64_tick = (cyc % 4 == 0);
    presc_tick = (cyc % 3 == 0);
  end

  bit ph[$];
  logic [15:0] mcnt;
  logic [6:0]  mctl;
  logic min_f, mov_f, m_i, m_e, m_ov;

  function automatic bit m_edge();
    bit c = ph[1], p = ph[2];
    return mctl[2] ? (c && !p) : (!c && p);
  endfunction

  function automatic bit m_inc();
    bit c = ph[1];
    bit act = mctl[2] ? !c : c;
    if (!mctl[0]) return 0;
    if (mctl[1]) return tmr_en && div64_tick && act;
    return m_edge();
  endfunction

  function automatic bit m_tick();
    if (!mctl[0]) return presc_tick;
    case (mctl[6:5])
      2'b01:   return m_inc();
      2'b10:   return m_inc() && (mcnt[7:0] == 8'hFF);
      2'b11:   return m_inc() && (mcnt == 16'hFFFF);
      default: return presc_tick;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = '{0, 0, 0};
      mcnt = '0; mctl = '0; min_f = 0; mov_f = 0;
    end else begin
      m_i  = m_inc();
      m_e  = m_edge();
      m_ov = m_i && mcnt == 16'hFFFF && !cnt_we;
      if (cnt_we) mcnt = cnt_wdata;
      else if (m_i) mcnt = mcnt + 16'd1;
      min_f = (mctl[0] && m_e) || (min_f && !(flag_clr_we && flag_clr[0]));
      mov_f = m_ov || (mov_f && !(flag_clr_we && flag_clr[1]));
      if (ctl_we) mctl = ctl_wdata;
      ph.push_front(pin_in);
      void'(ph.pop_back());
    end
  end

  int tick_cnt = 0, presc_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tcnt_tick) tick_cnt++;
      if (presc_tick) presc_cnt++;
      chk(acc_count == mcnt, "R3 R4 R6 R11 model count", acc_count, mcnt);
      chk(in_flag == min_f, "R3 R5 R7 model in_flag", in_flag, min_f);
      chk(ovf_flag == mov_f, "R6 R7 model ovf_flag", ovf_flag, mov_f);
      chk(irq_in == (min_f && mctl[3]), "R8 model irq_in", irq_in, min_f && mctl[3]);
      chk(irq_ovf == (mov_f && mctl[4]), "R8 model irq_ovf", irq_ovf, mov_f && mctl[4]);
      chk(tcnt_tick == m_tick(), "R9 R10 model tcnt_tick", tcnt_tick, m_tick());
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic wr_ctl(input logic [6:0] v);
    ctl_we = 1; ctl_wdata = v; step(1); ctl_we = 0;
  endtask
  task automatic load(input logic [15:0] v);
    cnt_we = 1; cnt_wdata = v; step(1); cnt_we = 0;
  endtask
  task automatic clr(input logic [1:0] m);
    flag_clr_we = 1; flag_clr = m; step(1); flag_clr_we = 0;
  endtask
  task automatic pulses(input int n);
    repeat (n) begin pin_in = 1; step(4); pin_in = 0; step(4); end
  endtask

  int saved;

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // r1_ reset state
    chk(acc_count == 0, "R1 count", acc_count, 0);
    chk(!in_flag && !ovf_flag, "R1 flags", {in_flag, ovf_flag}, 0);
    chk(!irq_in && !irq_ovf, "R1 irqs", {irq_in, irq_ovf}, 0);
    chk(tcnt_tick == presc_tick, "R1 tick", tcnt_tick, presc_tick);

    // R2 disabled: no counting, no flags; R11 load
    pulses(3); step(3);
    chk(acc_count == 0, "R2 disabled count", acc_count, 0);
    chk(!in_flag, "R2 disabled flag", in_flag, 0);
    load(16'h1234);
    chk(acc_count == 16'h1234, "R11 load", acc_count, 16'h1234);
    load(16'h0000);

    // R10 disabled with clock select 11
    wr_ctl(7'h60);
    tick_cnt = 0; presc_cnt = 0;
    pulses(4);
    chk(tick_cnt == presc_cnt, "R10 disabled select", tick_cnt, presc_cnt);

    // R3 falling edges with tmr_en=0 (R2 independence)
    wr_ctl(7'h01);
    pulses(5); step(3);
    chk(acc_count == 5, "R2 R3 falling count", acc_count, 5);
    chk(in_flag, "R3 flag on edge", in_flag, 1);
    clr(2'b01);
    chk(!in_flag, "R7 clear input flag", in_flag, 0);

    // R3 rising edges and latency
    load(16'h0000);
    wr_ctl(7'h05);
    step(2);
    pin_in = 1;
    step(1); chk(acc_count == 0, "R3 latency edge1", acc_count, 0);
    step(1); chk(acc_count == 0, "R3 latency edge2", acc_count, 0);
    step(1); chk(acc_count == 1, "R3 latency edge3", acc_count, 1);
    step(3); pin_in = 0; step(4);
    chk(acc_count == 1, "R3 no count on falling", acc_count, 1);
    pulses(2); step(3);
    chk(acc_count == 3, "R3 rising count", acc_count, 3);
    clr(2'b01);

    // R4 R5 gated, active high
    tmr_en = 1;
    wr_ctl(7'h03);
    load(16'h0000);
    pin_in = 1; step(40);
    chk(acc_count >= 8 && acc_count <= 12, "R4 gated high accum", acc_count, 10);
    chk(!in_flag, "R5 no flag while active", in_flag, 0);
    pin_in = 0; step(6);
    chk(in_flag, "R5 falling ends phase", in_flag, 1);
    saved = acc_count; step(20);
    chk(acc_count == saved, "R4 inactive holds", acc_count, saved);
    clr(2'b01);

    // R4 timer off stops gated accumulation
    tmr_en = 0;
    pin_in = 1; step(40);
    chk(acc_count == saved, "R4 timer off holds", acc_count, saved);
    pin_in = 0; step(6);
    clr(2'b01);

    // R4 R5 gated, active low
    tmr_en = 1;
    pin_in = 1; step(4);
    wr_ctl(7'h07);
    load(16'h0000);
    pin_in = 0; step(40);
    chk(acc_count >= 8 && acc_count <= 12, "R4 gated low accum", acc_count, 10);
    chk(!in_flag, "R5 no flag while low", in_flag, 0);
    pin_in = 1; step(6);
    chk(in_flag, "R5 rising ends phase", in_flag, 1);
    pin_in = 0; step(4);

    // R6 R8 overflow
    wr_ctl(7'h15);
    clr(2'b11);
    load(16'hFFFD);
    pulses(3); step(3);
    chk(acc_count == 0, "R6 wrap to zero", acc_count, 0);
    chk(ovf_flag, "R6 overflow flag", ovf_flag, 1);
    chk(irq_ovf, "R8 ovf irq enabled", irq_ovf, 1);
    chk(in_flag && !irq_in, "R8 input irq masked", irq_in, 0);
    clr(2'b10);
    chk(!ovf_flag && !irq_ovf, "R7 clear ovf", ovf_flag, 0);
    chk(in_flag, "R7 input flag kept", in_flag, 1);
    wr_ctl(7'h1D);
    chk(irq_in, "R8 input irq enabled", irq_in, 1);
    clr(2'b11);

    // R9 clock selection
    wr_ctl(7'h25);
    tick_cnt = 0;
    pulses(4); step(3);
    chk(tick_cnt == 4, "R9 select 01", tick_cnt, 4);
    wr_ctl(7'h45);
    load(16'h00FE);
    tick_cnt = 0;
    pulses(3); step(3);
    chk(tick_cnt == 1, "R9 select 10", tick_cnt, 1);
    chk(acc_count == 16'h0101, "R9 select 10 count", acc_count, 16'h0101);
    wr_ctl(7'h65);
    load(16'hFFFE);
    tick_cnt = 0;
    pulses(3); step(3);
    chk(tick_cnt == 1, "R9 select 11", tick_cnt, 1);
    wr_ctl(7'h05);
    tick_cnt = 0; presc_cnt = 0;
    step(30);
    chk(tick_cnt == presc_cnt && presc_cnt > 0, "R9 select 00", tick_cnt, presc_cnt);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule